// File: doc/BRIEF.md
# Replicated Two-Read One-Write Register File

This block is the operand store of a small three-stage processor pipeline: the operand-fetch stage reads two source registers while the execute stage writes one result register, and all three addresses may be live in the same clock cycle. No storage array with three ports is needed. The file is made from two identical banks, each with one write port and one read port. Every write is broadcast to both banks with the same address, data and enable. Each bank serves exactly one of the two read addresses, so the two copies always hold the same words.

Writes take effect on the rising clock edge when the write enable is high. Reads are combinational from the current contents. A parameter selects what a read returns when its address matches the address being written in the same cycle. In the new-data policy the incoming write data is forwarded to the read port. In the old-data policy the read returns the word stored before the edge. A second parameter chooses whether reset clears every register to zero. When it is off, the contents after reset are undefined until they are written. Each bank brings out only its read-address port. The bank's write-address view is not built, because nothing would use it.

The default shape is 32 registers of 32 bits with 5-bit addresses. The control pins are plain level signals with no handshake: a read is always valid, and a write is always accepted in the cycle its enable is high, so there is no back-pressure.

Top module: `dual_read_regfile`

## Requirements
- R1: When `wr_en` is 1 at a rising edge of `clk`, the word `wr_data` is stored at `wr_addr`, and from that edge on it is returned on both `rd_data_a` and `rd_data_b` whenever the matching read address selects it.
- R2: When `wr_en` is 0 at an edge, no register changes, whatever values `wr_addr` and `wr_data` carry.
- R3: A write to one address and reads of two other addresses may all happen in the same cycle, and each read returns its own register's stored word.
- R4: With `HIT_POLICY` = `HIT_NEW` (the default), a read whose address equals `wr_addr` while `wr_en` is 1 returns `wr_data` in that same cycle.
- R5: With `HIT_POLICY` = `HIT_OLD`, a read whose address equals `wr_addr` while `wr_en` is 1 returns the word stored before the edge, and returns the new word after the edge.
- R6: The two banks always hold the same contents, so `rd_data_a` and `rd_data_b` are equal whenever `rd_addr_a` equals `rd_addr_b` and no write is in progress.
- R7: With `CLEAR_ON_RESET` = 1, every register reads 0 after `rst_n` (active low) has been asserted. With it at 0, reset leaves the contents undefined.
- R8: Reads are combinational: a change of `rd_addr_a` or `rd_addr_b` between clock edges changes the matching read data with no clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset (clears contents only when CLEAR_ON_RESET = 1) |
| wr_en | input | 1 | Write enable from the execute stage |
| wr_addr | input | ADDR_W (5) | Destination register address |
| wr_data | input | DATA_W (32) | Word to write |
| rd_addr_a | input | ADDR_W (5) | First source register address |
| rd_data_a | output | DATA_W (32) | Word read for the first source |
| rd_addr_b | input | ADDR_W (5) | Second source register address |
| rd_data_b | output | DATA_W (32) | Word read for the second source |

## Verification
A write and a read of the same register can fall in the same cycle, and the chosen hit policy decides which value the read returns. The bench provokes this collision by driving `wr_addr` equal to `rd_addr_a` with `wr_en` high, while `rd_addr_b` points at a different register. Two instances take the same stimulus, one with each policy. In the collision cycle the new-data instance must show the incoming word and the old-data instance the previous word. After the edge both must show the new word, and both read ports must still agree with the bench's own model.

// File: rtl/rf_pkg.sv
package rf_pkg;

  // What a read returns when it hits the register being written this cycle
  typedef enum logic {
    HIT_OLD = 1'b0,
    HIT_NEW = 1'b1
  } hit_policy_e;

  localparam int NUM_RD_PORTS = 2;

endpackage

// File: rtl/rf_bank.sv
// One storage copy: a single write port and a single combinational read port.
module rf_bank #(
  parameter int DATA_W         = 32,
  parameter int DEPTH          = 32,
  parameter bit CLEAR_ON_RESET = 1'b0,
  localparam int ADDR_W        = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] mem [DEPTH];

  generate
    if (CLEAR_ON_RESET) begin : g_clear
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int i = 0; i < DEPTH; i++) begin
            mem[i] <= '0;
          end
        end else if (wr_en) begin
          mem[wr_addr] <= wr_data;
        end
      end
    end else begin : g_noclear
      always_ff @(posedge clk) begin
        if (wr_en) begin
          mem[wr_addr] <= wr_data;
        end
      end
    end
  endgenerate

  assign rd_data = mem[rd_addr];

  // R1
  write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (mem[$past(wr_addr)] == $past(wr_data)));

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!wr_en) && $stable(rd_addr)) |-> $stable(rd_data));

endmodule

// File: rtl/rf_read_port.sv
// Write-to-read forwarding for one read port (used only with the new-data policy).
module rf_read_port #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] bank_data,
  output logic [DATA_W-1:0] rd_data
);

  logic hit;

  always_comb begin
    hit     = wr_en && (wr_addr == rd_addr);
    rd_data = hit ? wr_data : bank_data;
  end

endmodule

// File: rtl/dual_read_regfile.sv
module dual_read_regfile
  import rf_pkg::*;
#(
  parameter int          DATA_W         = 32,
  parameter int          DEPTH          = 32,
  parameter hit_policy_e HIT_POLICY     = HIT_NEW,
  parameter bit          CLEAR_ON_RESET = 1'b0,
  localparam int         ADDR_W         = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr_a,
  output logic [DATA_W-1:0] rd_data_a,
  input  logic [ADDR_W-1:0] rd_addr_b,
  output logic [DATA_W-1:0] rd_data_b
);

  logic [ADDR_W-1:0] rd_addr_v [NUM_RD_PORTS];
  logic [DATA_W-1:0] bank_v    [NUM_RD_PORTS];
  logic [DATA_W-1:0] rd_v      [NUM_RD_PORTS];

  assign rd_addr_v[0] = rd_addr_a;
  assign rd_addr_v[1] = rd_addr_b;
  assign rd_data_a    = rd_v[0];
  assign rd_data_b    = rd_v[1];

  // One bank per read port; every bank sees the same write broadcast
  generate
    for (genvar g = 0; g < NUM_RD_PORTS; g++) begin : g_port
      rf_bank #(
        .DATA_W        (DATA_W),
        .DEPTH         (DEPTH),
        .CLEAR_ON_RESET(CLEAR_ON_RESET)
      ) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .rd_addr(rd_addr_v[g]),
        .rd_data(bank_v[g])
      );

      if (HIT_POLICY == HIT_NEW) begin : g_fwd
        rf_read_port #(
          .DATA_W(DATA_W),
          .ADDR_W(ADDR_W)
        ) u_rport (
          .wr_en    (wr_en),
          .wr_addr  (wr_addr),
          .wr_data  (wr_data),
          .rd_addr  (rd_addr_v[g]),
          .bank_data(bank_v[g]),
          .rd_data  (rd_v[g])
        );
      end else begin : g_direct
        assign rd_v[g] = bank_v[g];
      end
    end
  endgenerate

  // R6
  banks_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_en) && !wr_en && (rd_addr_a == $past(wr_addr)) && (rd_addr_b == rd_addr_a))
      |-> (rd_data_a == rd_data_b));

  generate
    if (HIT_POLICY == HIT_NEW) begin : g_fwd_chk
      // R4
      bypass_new_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (rd_addr_b == wr_addr)) |-> (rd_data_b == wr_data));
    end
  endgenerate

endmodule

// File: tb/dual_read_regfile_bench.sv
module dual_read_regfile_bench;
  import rf_pkg::*;

  localparam int DW = 32;
  localparam int NR = 32;
  localparam int AW = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [AW-1:0] ra = '0;
  logic [AW-1:0] rb = '0;
  logic [DW-1:0] new_a, new_b, old_a, old_b;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [DW-1:0] model [NR];

  always #5 clk = ~clk;

  dual_read_regfile #(.HIT_POLICY(HIT_NEW), .CLEAR_ON_RESET(1'b0)) u_dual_read_regfile (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr_a(ra), .rd_data_a(new_a), .rd_addr_b(rb), .rd_data_b(new_b));

  dual_read_regfile #(.HIT_POLICY(HIT_OLD), .CLEAR_ON_RESET(1'b1)) u_dual_read_regfile_old (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr_a(ra), .rd_data_a(old_a), .rd_addr_b(rb), .rd_data_b(old_b));

  task automatic check(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [DW-1:0] pat(input int i, input int salt);
    return (32'h9E37_79B9 * (i + 1)) ^ (salt << 8) ^ i;
  endfunction

  // Single write cycle, committed on the rising edge in between
  task automatic do_write(input int a, input logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    model[a] = d;
  endtask

  task automatic read_both(input int a, input int b);
    ra = AW'(a); rb = AW'(b);
    #1;
  endtask

  task automatic t_reset_clear;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < NR; i++) begin
      read_both(i, NR - 1 - i);
      check("R7 cleared port a", old_a, '0);
      check("R7 cleared port b", old_b, '0);
    end
  endtask

  task automatic t_fill_and_compare;
    for (int i = 0; i < NR; i++) do_write(i, pat(i, 1));
    @(negedge clk);
    for (int i = 0; i < NR; i++) begin
      read_both(i, i);
      check("R1 port a after write", new_a, model[i]);
      check("R6 banks agree", new_b, new_a);
      check("R6 banks agree (old inst)", old_b, old_a);
      check("R1 old inst", old_a, model[i]);
    end
    for (int i = 0; i < NR; i++) begin
      read_both(i, NR - 1 - i);
      check("R1 crossed port a", new_a, model[i]);
      check("R1 crossed port b", new_b, model[NR - 1 - i]);
    end
  endtask

  task automatic t_overwrite;
    // R1: a second write to the same register replaces the first
    do_write(12, 32'hAAAA_5555);
    do_write(12, 32'h0F0F_F0F0);
    @(negedge clk);
    read_both(12, 12);
    check("R1 last write wins a", new_a, 32'h0F0F_F0F0);
    check("R1 last write wins b", old_b, 32'h0F0F_F0F0);
  endtask

  task automatic t_disabled_write;
    @(negedge clk);
    wr_en = 1'b0; wr_addr = 5'd3; wr_data = 32'hDEAD_BEEF;
    ra = 5'd3; rb = 5'd3;
    @(negedge clk);
    @(negedge clk);
    #1;
    check("R2 no write when disabled a", new_a, model[3]);
    check("R2 no write when disabled b", old_b, model[3]);
  endtask

  task automatic t_three_addresses;
    do_write(7, 32'h1111_2222);
    do_write(8, 32'h3333_4444);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 5'd9; wr_data = 32'h5555_6666;
    ra = 5'd7; rb = 5'd8;
    #1;
    check("R3 port a during write elsewhere", new_a, 32'h1111_2222);
    check("R3 port b during write elsewhere", new_b, 32'h3333_4444);
    check("R3 old inst port b", old_b, 32'h3333_4444);
    @(negedge clk);
    wr_en = 1'b0;
    model[9] = 32'h5555_6666;
    read_both(9, 9);
    check("R3 third address written", new_a, 32'h5555_6666);
    check("R3 third address written b", old_b, 32'h5555_6666);
  endtask

  task automatic t_collision;
    do_write(5, 32'hA1A1_A1A1);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 5'd5; wr_data = 32'hB2B2_B2B2;
    ra = 5'd5; rb = 5'd6;
    #1;
    check("R4 new policy forwards", new_a, 32'hB2B2_B2B2);
    check("R5 old policy keeps old", old_a, 32'hA1A1_A1A1);
    check("R3 other port unaffected", new_b, model[6]);
    rb = 5'd5;
    #1;
    check("R4 new policy forwards port b", new_b, 32'hB2B2_B2B2);
    check("R5 old policy port b", old_b, 32'hA1A1_A1A1);
    @(negedge clk);
    wr_en = 1'b0;
    model[5] = 32'hB2B2_B2B2;
    #1;
    check("R5 old policy after edge", old_a, 32'hB2B2_B2B2);
    check("R4 new policy after edge", new_a, 32'hB2B2_B2B2);
    check("R6 ports agree after collision", old_b, old_a);
  endtask

  task automatic t_comb_read;
    @(negedge clk);
    ra = 5'd1; rb = 5'd30;
    #1;
    check("R8 comb read a=1", new_a, model[1]);
    check("R8 comb read b=30", new_b, model[30]);
    ra = 5'd2; rb = 5'd29;
    #1;
    check("R8 comb read a=2 without edge", new_a, model[2]);
    check("R8 comb read b=29 without edge", old_b, model[29]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    t_reset_clear();
    t_fill_and_compare();
    t_overwrite();
    t_disabled_write();
    t_three_addresses();
    t_collision();
    t_comb_read();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule